// File: doc/BRIEF.md
# Processor Interrupt and Wait-Synchronisation Front End

This block sits next to a small processor sequencer and turns its raw external event lines into clean, prioritised service decisions. Four asynchronous lines come in: a level-sensitive maskable request, an edge-sensitive non-maskable request, a test line polled by the wait instruction, and an active-low hardware reset request. Each passes through a two-stage synchroniser before any logic uses it. A rising edge on the non-maskable line is caught in a pending flag, which holds until that event is serviced.

Decisions are made only when the sequencer flags an instruction boundary, or on every cycle while the processor idles in a wait. The winner is reported for one cycle on a service strobe with a two-bit vector code. Reset wins over a pending non-maskable event, which wins over an enabled maskable request. Only a maskable service drives the active-low acknowledge output, which stays low for a fixed number of cycles.

When the sequencer signals that a wait instruction is executing and the synchronised test line is high, the block raises a stall and idles. In that state it re-examines the test line on every cycle. When the line drops, the block clears the stall and gives a one-cycle resume strobe. A serviceable request that arrives during the idle state also ends it, through a service instead of a resume.

Top module: `irq_wait_front`

## Requirements
- R1: A level change on any asynchronous input (`intr_req`, `nmi_req`, `test_in`, `hw_reset_n`) takes no part in a decision made at the first or second rising edge after the change. It is first used at the third edge.
- R2: When `insn_bound` is high at a rising edge, the synchronised maskable request is high, `int_en` is high and nothing of higher priority is present, `svc_valid` is high for the following cycle with `svc_vec` = 2'b11. Without a boundary strobe or the idle state, no service is issued. When `svc_valid` is low, `svc_vec` reads 2'b00.
- R3: A maskable service drives `ack_n` low for exactly ACK_LEN (default 2) cycles, starting in the cycle where `svc_valid` is high. Non-maskable and reset services leave `ack_n` high.
- R4: While `int_en` is low, a maskable request produces no service and no acknowledge.
- R5: A 0-to-1 transition of `nmi_req` is held pending until it is serviced, even if the line has already returned to 0. It is serviced at the next decision with `svc_vec` = 2'b10, and that service clears it.
- R6: Holding `nmi_req` high produces only one non-maskable service. Only a new rising transition produces another.
- R7: The decision priority is reset (2'b01), then a pending non-maskable event (2'b10), then an enabled maskable request (2'b11).
- R8: A `wait_exec` strobe while the synchronised test line is 1 raises `stall` in the next cycle, and `stall` holds while the line stays 1. A `wait_exec` strobe with the line at 0 leaves `stall` and `resume` low.
- R9: While idle, when the synchronised test line reads 0 the block drops `stall` and pulses `resume` high for one cycle, both in the same cycle.
- R10: An enabled maskable request or a pending non-maskable event seen in the idle state ends the idle state with a service. In that case `stall` drops in the same cycle as `svc_valid` and no `resume` pulse occurs.
- R11: While the synchronised `hw_reset_n` is low, the pending non-maskable event is discarded and the idle state is left. A decision made in that time selects the reset vector.
- R12: A boundary strobe that comes while the acknowledge pulse is still low does not start a second maskable service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block |
| intr_req | input | 1 | Asynchronous maskable request, active high |
| nmi_req | input | 1 | Asynchronous non-maskable request, taken on its rising edge |
| test_in | input | 1 | Asynchronous test line polled by the wait instruction |
| hw_reset_n | input | 1 | Asynchronous hardware reset request, active low |
| int_en | input | 1 | Interrupt enable flag for maskable requests |
| wait_exec | input | 1 | One-cycle strobe: wait instruction executing |
| insn_bound | input | 1 | One-cycle strobe: instruction boundary reached |
| ack_n | output | 1 | Active-low acknowledge pulse for maskable services |
| svc_valid | output | 1 | One-cycle strobe: a service was chosen |
| svc_vec | output | 2 | Chosen service: 01 reset, 10 non-maskable, 11 maskable, 00 none |
| stall | output | 1 | Holds the sequencer while idling in a wait |
| resume | output | 1 | One-cycle strobe: wait finished, continue with next instruction |

## Verification
The hardest situations to produce are exits from the idle state, because they depend on how the synchroniser latency lines up against the idle loop. A test falling edge, a maskable request and a non-maskable edge can each end the idle state, and each reaches the decision logic at a different edge. The bench first parks the block in the idle state by holding the test line high and issuing a wait strobe. It then changes one asynchronous line at a falling clock edge and counts rising edges to the exact cycle in which `stall`, `resume` and `svc_valid` must change. Before that cycle it confirms that nothing has moved. A hardware reset applied during the idle state, and a pending non-maskable event discarded by that reset, are reached the same way.

// File: rtl/irqw_pkg.sv
package irqw_pkg;

    // Service vector codes reported on svc_vec
    typedef enum logic [1:0] {
        VEC_NONE  = 2'b00,
        VEC_RESET = 2'b01,
        VEC_NMI   = 2'b10,
        VEC_MASK  = 2'b11
    } svc_vec_e;

    // Wait/test loop states
    typedef enum logic {
        WS_RUN  = 1'b0,
        WS_IDLE = 1'b1
    } wait_state_e;

    // Bit positions of the asynchronous inputs inside the synchroniser bus
    localparam int SYNC_W    = 4;
    localparam int BIT_TEST  = 0;
    localparam int BIT_INTR  = 1;
    localparam int BIT_NMI   = 2;
    localparam int BIT_HWRST = 3;

    // Reset values of the synchroniser stages (reset request line idles high)
    localparam logic [SYNC_W-1:0] SYNC_RST_VAL = 4'b1000;

    // Synchronised event set used by the arbitration
    typedef struct packed {
        logic rst_act;
        logic nmi_lvl;
        logic intr_lvl;
        logic test_hi;
    } evt_s;

    // Fixed-priority choice: reset, then non-maskable, then maskable
    function automatic svc_vec_e pick_vec(input logic want_rst,
                                          input logic want_nmi,
                                          input logic want_mask);
        svc_vec_e v;
        if (want_rst)       v = VEC_RESET;
        else if (want_nmi)  v = VEC_NMI;
        else if (want_mask) v = VEC_MASK;
        else                v = VEC_NONE;
        return v;
    endfunction

endpackage

// File: rtl/irqw_sync.sv
module irqw_sync #(
    parameter int              W       = 4,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= RST_VAL;
                else     stg[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[i] <= RST_VAL;
                else     stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/irqw_nmi_latch.sv
module irqw_nmi_latch (
    input  logic clk,
    input  logic rst,
    input  logic clr,      // hardware reset request active
    input  logic nmi_s,    // synchronised non-maskable line
    input  logic take,     // non-maskable service chosen this cycle
    output logic pend
);

    logic nmi_d;
    logic rise;

    assign rise = nmi_s & ~nmi_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi_d <= 1'b0;
            pend  <= 1'b0;
        end else begin
            nmi_d <= nmi_s;
            if (clr)       pend <= 1'b0;
            else if (rise) pend <= 1'b1;
            else if (take) pend <= 1'b0;
        end
    end

    // R5: a pending event stays until it is serviced or discarded
    p_pend_hold_r5: assert property (@(posedge clk) disable iff (rst)
        pend && !take && !clr |=> pend);

endmodule

// File: rtl/irqw_ack_pulse.sv
module irqw_ack_pulse #(
    parameter int ACK_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic start,
    output logic ack_n,
    output logic busy
);

    localparam int CW = $clog2(ACK_LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)        cnt <= '0;
        else if (start)        cnt <= CW'(ACK_LEN);
        else if (cnt != '0)    cnt <= cnt - CW'(1);
    end

    assign busy  = (cnt != '0);
    assign ack_n = ~busy;

    if (ACK_LEN >= 2) begin : g_len_chk
        // R3: once low, the acknowledge stays low at least one more cycle
        p_ack_hold_r3: assert property (@(posedge clk) disable iff (rst)
            $fell(ack_n) && !clr |=> !ack_n);
    end

endmodule

// File: rtl/irqw_wait_fsm.sv
module irqw_wait_fsm
    import irqw_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr,        // hardware reset request active
    input  logic wait_exec,
    input  logic test_hi,    // synchronised test line
    input  logic svc_fire,   // a service is chosen this cycle
    output logic stall,
    output logic resume
);

    wait_state_e state, state_nx;
    logic        resume_nx;

    always_comb begin
        state_nx  = state;
        resume_nx = 1'b0;
        unique case (state)
            WS_RUN: begin
                if (wait_exec && test_hi && !svc_fire && !clr)
                    state_nx = WS_IDLE;
            end
            WS_IDLE: begin
                if (clr || svc_fire) begin
                    state_nx = WS_RUN;
                end else if (!test_hi) begin
                    state_nx  = WS_RUN;
                    resume_nx = 1'b1;
                end
            end
            default: state_nx = WS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WS_RUN;
            resume <= 1'b0;
        end else begin
            state  <= state_nx;
            resume <= resume_nx;
        end
    end

    assign stall = (state == WS_IDLE);

    // R8: stall only starts after a wait strobe with the test line high
    p_stall_entry_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(stall) |-> $past(wait_exec) && $past(test_hi));

    // R9: resume marks the end of an idle period
    p_resume_exit_r9: assert property (@(posedge clk) disable iff (rst)
        resume |-> !stall && $past(stall));

endmodule

// File: rtl/irq_wait_front.sv
module irq_wait_front
    import irqw_pkg::*;
#(
    parameter int ACK_LEN     = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       intr_req,
    input  logic       nmi_req,
    input  logic       test_in,
    input  logic       hw_reset_n,
    input  logic       int_en,
    input  logic       wait_exec,
    input  logic       insn_bound,
    output logic       ack_n,
    output logic       svc_valid,
    output logic [1:0] svc_vec,
    output logic       stall,
    output logic       resume
);

    logic [SYNC_W-1:0] raw_in;
    logic [SYNC_W-1:0] sync_q;
    evt_s              ev;

    logic     nmi_pend;
    logic     ack_busy;
    logic     take;
    svc_vec_e vec_nx;
    logic     fire;

    logic     svc_valid_q;
    svc_vec_e svc_vec_q;

    // ---------------- input synchronisation ----------------
    always_comb begin
        raw_in            = '0;
        raw_in[BIT_TEST]  = test_in;
        raw_in[BIT_INTR]  = intr_req;
        raw_in[BIT_NMI]   = nmi_req;
        raw_in[BIT_HWRST] = hw_reset_n;
    end

    irqw_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST_VAL)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw_in),
        .q   (sync_q)
    );

    always_comb begin
        ev.rst_act  = ~sync_q[BIT_HWRST];
        ev.nmi_lvl  =  sync_q[BIT_NMI];
        ev.intr_lvl =  sync_q[BIT_INTR];
        ev.test_hi  =  sync_q[BIT_TEST];
    end

    // ---------------- non-maskable edge latch ----------------
    irqw_nmi_latch u_nmi (
        .clk   (clk),
        .rst   (rst),
        .clr   (ev.rst_act),
        .nmi_s (ev.nmi_lvl),
        .take  (vec_nx == VEC_NMI),
        .pend  (nmi_pend)
    );

    // ---------------- arbitration ----------------
    assign take = insn_bound | stall;

    always_comb begin
        if (take)
            vec_nx = pick_vec(ev.rst_act,
                              nmi_pend,
                              ev.intr_lvl & int_en & ~ack_busy);
        else
            vec_nx = VEC_NONE;
    end

    assign fire = (vec_nx != VEC_NONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_valid_q <= 1'b0;
            svc_vec_q   <= VEC_NONE;
        end else begin
            svc_valid_q <= fire;
            svc_vec_q   <= vec_nx;
        end
    end

    assign svc_valid = svc_valid_q;
    assign svc_vec   = svc_vec_q;

    // ---------------- acknowledge pulse ----------------
    irqw_ack_pulse #(
        .ACK_LEN (ACK_LEN)
    ) u_ack (
        .clk   (clk),
        .rst   (rst),
        .clr   (ev.rst_act),
        .start (vec_nx == VEC_MASK),
        .ack_n (ack_n),
        .busy  (ack_busy)
    );

    // ---------------- wait / test loop ----------------
    irqw_wait_fsm u_wait (
        .clk       (clk),
        .rst       (rst),
        .clr       (ev.rst_act),
        .wait_exec (wait_exec),
        .test_hi   (ev.test_hi),
        .svc_fire  (fire),
        .stall     (stall),
        .resume    (resume)
    );

    // ---------------- assertions ----------------
    // R2: a service follows a boundary strobe or an idle cycle
    p_svc_origin_r2: assert property (@(posedge clk) disable iff (rst)
        svc_valid |-> $past(insn_bound) || $past(stall));

    // R3: the acknowledge only falls with a maskable service
    p_ack_only_mask_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(ack_n) |-> svc_valid && (svc_vec == 2'b11));

    // R4: maskable services need the enable flag
    p_mask_gated_r4: assert property (@(posedge clk) disable iff (rst)
        svc_valid && (svc_vec == 2'b11) |-> $past(int_en));

    // R7: a service chosen while reset is requested is the reset service
    p_reset_first_r7: assert property (@(posedge clk) disable iff (rst)
        svc_valid && $past(ev.rst_act) |-> svc_vec == 2'b01);

    // R2: no vector code without the strobe
    p_vec_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !svc_valid |-> svc_vec == 2'b00);

endmodule

// File: tb/irq_wait_front_tb.sv
module irq_wait_front_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       intr_req, nmi_req, test_in, hw_reset_n;
    logic       int_en, wait_exec, insn_bound;
    logic       ack_n, svc_valid, stall, resume;
    logic [1:0] svc_vec;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    irq_wait_front u_dut (
        .clk        (clk),
        .rst        (rst),
        .intr_req   (intr_req),
        .nmi_req    (nmi_req),
        .test_in    (test_in),
        .hw_reset_n (hw_reset_n),
        .int_en     (int_en),
        .wait_exec  (wait_exec),
        .insn_bound (insn_bound),
        .ack_n      (ack_n),
        .svc_valid  (svc_valid),
        .svc_vec    (svc_vec),
        .stall      (stall),
        .resume     (resume)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // boundary strobe sampled at the next rising edge; returns at the following negedge
    task automatic bound_pulse();
        insn_bound = 1'b1;
        tick(1);
        insn_bound = 1'b0;
    endtask

    task automatic wait_pulse();
        wait_exec = 1'b1;
        tick(1);
        wait_exec = 1'b0;
    endtask

    task automatic t_reset_state();
        chk("R2 reset svc_valid", svc_valid, 0);
        chk("R2 reset svc_vec", svc_vec, 0);
        chk("R3 reset ack_n", ack_n, 1);
        chk("R8 reset stall", stall, 0);
        chk("R9 reset resume", resume, 0);
    endtask

    task automatic t_mask_path();
        int_en   = 1'b1;
        intr_req = 1'b1;
        tick(1);
        bound_pulse();                       // decision at 2nd edge after change
        chk("R1 too early", svc_valid, 0);
        bound_pulse();                       // decision at 3rd edge
        chk("R2 mask svc", svc_valid, 1);
        chk("R2 mask vec", svc_vec, 2'b11);
        chk("R3 ack low 1st", ack_n, 0);
        bound_pulse();                       // boundary during acknowledge
        chk("R12 no retrigger", svc_valid, 0);
        chk("R3 ack low 2nd", ack_n, 0);
        tick(1);
        chk("R3 ack high after", ack_n, 1);
        for (int i = 0; i < 4; i++) begin
            tick(1);
            chk("R2 no boundary no svc", svc_valid, 0);
        end
        intr_req = 1'b0;
        tick(3);
    endtask

    task automatic t_mask_disabled();
        int_en   = 1'b0;
        intr_req = 1'b1;
        tick(3);
        bound_pulse();
        chk("R4 disabled svc", svc_valid, 0);
        chk("R4 disabled ack", ack_n, 1);
        tick(1);
        chk("R4 disabled ack later", ack_n, 1);
        intr_req = 1'b0;
        tick(3);
    endtask

    task automatic t_nmi();
        nmi_req = 1'b1;
        tick(3);
        nmi_req = 1'b0;
        tick(3);
        bound_pulse();
        chk("R5 latched nmi svc", svc_valid, 1);
        chk("R5 latched nmi vec", svc_vec, 2'b10);
        chk("R3 no ack for nmi", ack_n, 1);
        bound_pulse();
        chk("R5 pending cleared", svc_valid, 0);
        nmi_req = 1'b1;
        tick(4);
        bound_pulse();
        chk("R6 first level svc", svc_vec, 2'b10);
        tick(4);
        bound_pulse();
        chk("R6 held level no svc", svc_valid, 0);
        nmi_req = 1'b0;
        tick(3);
    endtask

    task automatic t_priority();
        int_en   = 1'b1;
        intr_req = 1'b1;
        nmi_req  = 1'b1;
        tick(4);
        bound_pulse();
        chk("R7 nmi over mask", svc_vec, 2'b10);
        chk("R3 ack high on nmi", ack_n, 1);
        bound_pulse();
        chk("R7 mask after nmi", svc_vec, 2'b11);
        tick(3);
        nmi_req = 1'b0;
        tick(3);
        nmi_req = 1'b1;
        tick(4);                             // new pending edge
        hw_reset_n = 1'b0;
        tick(3);
        bound_pulse();
        chk("R7 reset over all", svc_vec, 2'b01);
        chk("R3 ack high on reset", ack_n, 1);
        hw_reset_n = 1'b1;
        intr_req   = 1'b0;
        int_en     = 1'b0;
        tick(4);
        bound_pulse();
        chk("R11 nmi discarded", svc_valid, 0);
        nmi_req = 1'b0;
        tick(3);
    endtask

    task automatic t_wait_test();
        test_in = 1'b0;
        tick(3);
        wait_pulse();
        chk("R8 test low no stall", stall, 0);
        tick(2);
        chk("R8 test low no resume", resume, 0);
        chk("R8 test low stall later", stall, 0);
        test_in = 1'b1;
        tick(3);
        wait_pulse();
        chk("R8 stall raised", stall, 1);
        for (int i = 0; i < 5; i++) begin
            tick(1);
            chk("R8 stall held", stall, 1);
            chk("R2 idle no svc", svc_valid, 0);
        end
        test_in = 1'b0;
        tick(2);
        chk("R1 stall before 3rd edge", stall, 1);
        chk("R9 no early resume", resume, 0);
        tick(1);
        chk("R9 resume pulse", resume, 1);
        chk("R9 stall dropped", stall, 0);
        tick(1);
        chk("R9 resume one cycle", resume, 0);
    endtask

    task automatic t_idle_exit();
        int_en  = 1'b1;
        test_in = 1'b1;
        tick(3);
        wait_pulse();
        chk("R10 idle entered", stall, 1);
        intr_req = 1'b1;
        tick(2);
        chk("R10 mask not yet", svc_valid, 0);
        tick(1);
        chk("R10 mask exit svc", svc_vec, 2'b11);
        chk("R10 mask exit stall", stall, 0);
        chk("R10 mask exit no resume", resume, 0);
        chk("R3 ack on idle exit", ack_n, 0);
        intr_req = 1'b0;
        tick(4);
        wait_pulse();
        chk("R10 idle again", stall, 1);
        nmi_req = 1'b1;
        tick(3);
        chk("R10 nmi not yet", stall, 1);
        tick(1);
        chk("R10 nmi exit svc", svc_vec, 2'b10);
        chk("R10 nmi exit stall", stall, 0);
        chk("R10 nmi exit no resume", resume, 0);
        nmi_req = 1'b0;
        int_en  = 1'b0;
        tick(3);
    endtask

    task automatic t_reset_in_idle();
        wait_pulse();
        chk("R11 idle before reset", stall, 1);
        hw_reset_n = 1'b0;
        tick(2);
        chk("R11 still idle", stall, 1);
        tick(1);
        chk("R11 reset svc", svc_vec, 2'b01);
        chk("R11 idle left", stall, 0);
        chk("R11 no resume", resume, 0);
        tick(1);
        chk("R11 single svc", svc_valid, 0);
        hw_reset_n = 1'b1;
        test_in    = 1'b0;
        tick(4);
    endtask

    initial begin
        rst = 1'b1;
        intr_req = 1'b0; nmi_req = 1'b0; test_in = 1'b0; hw_reset_n = 1'b1;
        int_en = 1'b0; wait_exec = 1'b0; insn_bound = 1'b0;
        tick(4);
        rst = 1'b0;
        tick(3);
        t_reset_state();
        t_mask_path();
        t_mask_disabled();
        t_nmi();
        t_priority();
        t_wait_test();
        t_idle_exit();
        t_reset_in_idle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule